// File: doc/BRIEF.md
# Lane-Aware Dynamic Warp Regrouping Pool

This block sits after branch commit in a SIMT core and rebuilds warps from scalar threads. Each commit presents up to two thread groups. One group carries the threads that took the branch and the other carries the threads that fell through. Each group has its own destination PC. The block keeps a small table that maps a PC to the warp currently being assembled for that PC, together with the lanes that warp already fills. Incoming threads join that warp when their lanes are free. If the PC has no such warp, or a lane is already taken, the block opens a new warp instead.

Assembled warps wait in a pool slot ring. The issue side always receives the oldest one. A thread keeps its home lane, which is the low bits of its thread ID, so regrouping never moves operands between lanes. When the pool has no room for the worst case of two new warps, the commit side is held off through a ready signal. No threads are lost.

Top module: `dwf_pool`

## Requirements
- R1: After reset, `iss_valid` is 0 and `cm_ready` is 1.
- R2: A group with no forming warp at its PC opens a new warp. That warp carries the group's PC, its lane mask, and the thread ID of each active lane in that lane's slot of `iss_tid`, with lane l at bits [l*TID_W +: TID_W]. Inactive lanes read 0. Every thread ID's low log2(LANES) bits equal its lane.
- R3: A group whose PC matches a forming warp, and whose lanes are all free in that warp, is merged into it. The mask becomes the OR of both, and each lane keeps the thread ID written into it.
- R4: A group whose lanes clash with the forming warp at its PC opens a new warp. Later groups for that PC merge into the new warp, not the older one.
- R5: When both groups are presented together, the taken group is applied first. The not-taken group then sees its result. Same-PC complementary groups form one warp, and otherwise the taken group's warp is older.
- R6: Warps leave in the order they were opened. A warp is removed on a cycle with `iss_valid` and `iss_ready` both 1.
- R7: Once a warp that is still forming has been issued, it takes no more threads. A later group for its PC, including one presented in the same cycle as the issue, opens a new warp.
- R8: `cm_ready` is 0 while more than DEPTH-2 warps are held. Groups presented while it is 0 are ignored and produce no warp.
- R9: A group with its request low, or with an all-zero lane mask, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tk_req | input | 1 | Taken group present |
| tk_pc | input | PC_W | Taken destination PC |
| tk_mask | input | LANES | Taken active lanes |
| tk_tid | input | LANES*TID_W | Taken thread IDs, one per lane |
| nt_req | input | 1 | Not-taken group present |
| nt_pc | input | PC_W | Not-taken destination PC |
| nt_mask | input | LANES | Not-taken active lanes |
| nt_tid | input | LANES*TID_W | Not-taken thread IDs, one per lane |
| cm_ready | output | 1 | Commit groups accepted this cycle |
| iss_valid | output | 1 | Oldest warp available |
| iss_ready | input | 1 | Issue takes the oldest warp |
| iss_pc | output | PC_W | PC of oldest warp |
| iss_mask | output | LANES | Lanes filled in oldest warp |
| iss_tid | output | LANES*TID_W | Thread IDs of oldest warp |

## Verification
The checks assume that every active lane's thread ID names that lane in its low bits. A property on each commit group flags any input that breaks this. The stimulus builds each ID as an origin-warp number times LANES plus the lane index, so the rule always holds. The checks also assume that a source facing a low `cm_ready` treats its group as not taken. The stall test leaves that group unretried and confirms that no warp came from it. Within one commit, the two groups are given complementary lanes whenever they share a PC, except in the one case that deliberately exercises a clash.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  parameter int LANES = 4;
  parameter int TID_W = 4;
  parameter int PC_W  = 8;
  parameter int DEPTH = 4;

  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic                 vld;
    logic [PC_W-1:0]      pc;
    logic [LANES-1:0]     occ;
    logic [IDX_W-1:0]     idx;
  } lut_ent_t;

  typedef struct packed {
    logic [PC_W-1:0]                 pc;
    logic [LANES-1:0]                msk;
    logic [LANES-1:0][TID_W-1:0]     tid;
  } warp_t;

  typedef struct packed {
    logic                            req;
    logic [PC_W-1:0]                 pc;
    logic [LANES-1:0]                msk;
    logic [LANES-1:0][TID_W-1:0]     tid;
  } grp_t;
endpackage

// File: rtl/dwf_update_stage.sv
module dwf_update_stage
  import dwf_pkg::*;
(
  input  logic                   en_i,
  input  grp_t                   grp_i,
  input  lut_ent_t [DEPTH-1:0]   lut_i,
  input  warp_t    [DEPTH-1:0]   pool_i,
  input  logic     [IDX_W-1:0]   tail_i,
  output lut_ent_t [DEPTH-1:0]   lut_o,
  output warp_t    [DEPTH-1:0]   pool_o,
  output logic     [IDX_W-1:0]   tail_o,
  output logic                   alloc_o
);
  logic             hit;
  logic             have_free;
  logic             active;
  logic             clash;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] slot;
  logic [IDX_W-1:0] entry;

  // PC lookup and free-entry search
  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lut_i[i].vld && (lut_i[i].pc == grp_i.pc)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!lut_i[i].vld && !have_free) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign active = en_i && grp_i.req && (|grp_i.msk);
  assign clash  = hit && (|(lut_i[hit_idx].occ & grp_i.msk));
  assign slot   = lut_i[hit_idx].idx;
  assign entry  = hit ? hit_idx : free_idx;

  // merge into forming warp, or open a new one at the tail
  always_comb begin
    lut_o   = lut_i;
    pool_o  = pool_i;
    tail_o  = tail_i;
    alloc_o = 1'b0;
    if (active) begin
      if (hit && !clash) begin
        pool_o[slot].msk = pool_i[slot].msk | grp_i.msk;
        for (int l = 0; l < LANES; l++) begin
          if (grp_i.msk[l]) pool_o[slot].tid[l] = grp_i.tid[l];
        end
        lut_o[hit_idx].occ = lut_i[hit_idx].occ | grp_i.msk;
      end else begin
        pool_o[tail_i].pc  = grp_i.pc;
        pool_o[tail_i].msk = grp_i.msk;
        for (int l = 0; l < LANES; l++) begin
          pool_o[tail_i].tid[l] = grp_i.msk[l] ? grp_i.tid[l] : '0;
        end
        lut_o[entry].vld = 1'b1;
        lut_o[entry].pc  = grp_i.pc;
        lut_o[entry].occ = grp_i.msk;
        lut_o[entry].idx = tail_i;
        tail_o  = tail_i + 1'b1;
        alloc_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dwf_ring_ctrl.sv
module dwf_ring_ctrl
  import dwf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_i,
  input  logic [1:0]       alloc_i,
  input  logic [IDX_W-1:0] tail_nxt_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);
  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             ring_en;

  assign ring_en = pop_i || (|alloc_i);

  always_comb begin
    head_d  = pop_i ? head_q + 1'b1 : head_q;
    tail_d  = tail_nxt_i;
    count_d = count_q - CNT_W'(pop_i) + CNT_W'(alloc_i[0]) + CNT_W'(alloc_i[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (ring_en) begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (count_q != '0));

  p_ring_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0 && count_q != CNT_W'(DEPTH)) |-> (CNT_W'(IDX_W'(tail_q - head_q)) == count_q));
endmodule

// File: rtl/dwf_pool.sv
module dwf_pool
  import dwf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tk_req,
  input  logic [PC_W-1:0]        tk_pc,
  input  logic [LANES-1:0]       tk_mask,
  input  logic [LANES*TID_W-1:0] tk_tid,
  input  logic                   nt_req,
  input  logic [PC_W-1:0]        nt_pc,
  input  logic [LANES-1:0]       nt_mask,
  input  logic [LANES*TID_W-1:0] nt_tid,
  output logic                   cm_ready,
  output logic                   iss_valid,
  input  logic                   iss_ready,
  output logic [PC_W-1:0]        iss_pc,
  output logic [LANES-1:0]       iss_mask,
  output logic [LANES*TID_W-1:0] iss_tid
);
  localparam int N_GRP = 2;

  lut_ent_t [DEPTH-1:0] lut_q, lut_d;
  warp_t    [DEPTH-1:0] pool_q, pool_d;
  lut_ent_t [DEPTH-1:0] lut_c  [N_GRP+1];
  warp_t    [DEPTH-1:0] pool_c [N_GRP+1];
  logic     [IDX_W-1:0] tail_c [N_GRP+1];
  grp_t                 grp    [N_GRP];
  logic     [N_GRP-1:0] alloc;

  logic [IDX_W-1:0] head;
  logic [IDX_W-1:0] tail;
  logic [CNT_W-1:0] count;
  logic             pop;
  logic             state_en;

  assign cm_ready  = (count <= CNT_W'(DEPTH - N_GRP));
  assign iss_valid = (count != '0);
  assign pop       = iss_valid && iss_ready;
  assign iss_pc    = pool_q[head].pc;
  assign iss_mask  = pool_q[head].msk;
  assign iss_tid   = pool_q[head].tid;

  // taken group first, then not-taken
  assign grp[0] = '{req: tk_req, pc: tk_pc, msk: tk_mask, tid: tk_tid};
  assign grp[1] = '{req: nt_req, pc: nt_pc, msk: nt_mask, tid: nt_tid};

  // issue leaves first: drop the lookup entry of the popped warp
  always_comb begin
    lut_c[0]  = lut_q;
    pool_c[0] = pool_q;
    tail_c[0] = tail;
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && lut_q[i].vld && (lut_q[i].idx == head)) lut_c[0][i].vld = 1'b0;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_stage
    dwf_update_stage u_stage (
      .en_i    (cm_ready),
      .grp_i   (grp[g]),
      .lut_i   (lut_c[g]),
      .pool_i  (pool_c[g]),
      .tail_i  (tail_c[g]),
      .lut_o   (lut_c[g+1]),
      .pool_o  (pool_c[g+1]),
      .tail_o  (tail_c[g+1]),
      .alloc_o (alloc[g])
    );
  end

  dwf_ring_ctrl u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_i      (pop),
    .alloc_i    (alloc),
    .tail_nxt_i (tail_c[N_GRP]),
    .head_o     (head),
    .tail_o     (tail),
    .count_o    (count)
  );

  always_comb begin
    lut_d    = lut_c[N_GRP];
    pool_d   = pool_c[N_GRP];
    state_en = pop || (cm_ready && (tk_req || nt_req));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_q  <= '0;
      pool_q <= '0;
    end else if (state_en) begin
      lut_q  <= lut_d;
      pool_q <= pool_d;
    end
  end

  // lookup entries agree with the warp they point at, and that warp is live
  for (genvar i = 0; i < DEPTH; i++) begin : g_lut_chk
    p_lut_matches_pool_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lut_q[i].vld |-> (pool_q[lut_q[i].idx].msk == lut_q[i].occ &&
                        pool_q[lut_q[i].idx].pc  == lut_q[i].pc));

    p_lut_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lut_q[i].vld |-> (CNT_W'(IDX_W'(lut_q[i].idx - head)) < count));

    for (genvar j = i + 1; j < DEPTH; j++) begin : g_pair
      p_lut_unique_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lut_q[i].vld && lut_q[j].vld && lut_q[i].pc == lut_q[j].pc));
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    p_tk_home_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tk_req && tk_mask[l]) |-> (tk_tid[l*TID_W +: LANE_W] == LANE_W'(l)));
    p_nt_home_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (nt_req && nt_mask[l]) |-> (nt_tid[l*TID_W +: LANE_W] == LANE_W'(l)));
  end

  p_iss_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (|iss_mask));

  p_stall_no_growth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_ready |=> (count <= $past(count)));
endmodule

// File: tb/dwf_pool_bench.sv
`timescale 1ns/1ps
module dwf_pool_bench;
  localparam int L  = 4;
  localparam int TW = 4;

  logic          clk;
  logic          rst_n;
  logic          tk_req, nt_req, iss_ready;
  logic [7:0]    tk_pc, nt_pc;
  logic [L-1:0]  tk_mask, nt_mask;
  logic [L*TW-1:0] tk_tid, nt_tid;
  logic          cm_ready, iss_valid;
  logic [7:0]    iss_pc;
  logic [L-1:0]  iss_mask;
  logic [L*TW-1:0] iss_tid;

  int checks = 0;
  int errors = 0;

  dwf_pool u_dwf_pool (
    .clk(clk), .rst_n(rst_n),
    .tk_req(tk_req), .tk_pc(tk_pc), .tk_mask(tk_mask), .tk_tid(tk_tid),
    .nt_req(nt_req), .nt_pc(nt_pc), .nt_mask(nt_mask), .nt_tid(nt_tid),
    .cm_ready(cm_ready), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_pc(iss_pc), .iss_mask(iss_mask), .iss_tid(iss_tid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [L*TW-1:0] mk_tid(input logic [L-1:0] m, input int w);
    logic [L*TW-1:0] t = '0;
    for (int l = 0; l < L; l++) if (m[l]) t[l*TW +: TW] = TW'(w*L + l);
    return t;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic commit(input logic tr, input logic [7:0] tp, input logic [L-1:0] tm, input int tw,
                        input logic nr, input logic [7:0] np, input logic [L-1:0] nm, input int nw);
    @(negedge clk);
    tk_req = tr; tk_pc = tp; tk_mask = tm; tk_tid = mk_tid(tm, tw);
    nt_req = nr; nt_pc = np; nt_mask = nm; nt_tid = mk_tid(nm, nw);
    @(negedge clk);
    tk_req = 1'b0; nt_req = 1'b0; tk_mask = '0; nt_mask = '0;
  endtask

  task automatic pop_expect(input logic [7:0] pc, input logic [L-1:0] m, input logic [L*TW-1:0] t, input string tag);
    logic [31:0] act, exp;
    #1;
    act = {3'b0, iss_valid, iss_pc, iss_mask, iss_tid};
    exp = {3'b0, 1'b1, pc, m, t};
    check(act == exp, tag, act, exp);
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    #1;
    check(iss_valid == 1'b0, tag, {31'b0, iss_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iss_ready = 1'b0;
    tk_req = 1'b0; tk_pc = '0; tk_mask = '0; tk_tid = '0;
    nt_req = 1'b0; nt_pc = '0; nt_mask = '0; nt_tid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(iss_valid == 1'b0 && cm_ready == 1'b1, "R1 reset", {30'b0, iss_valid, cm_ready}, 32'd1);

    // R2 R3 R4 R6 sweep over all lane-mask pairs at one PC
    for (int m1 = 1; m1 < 16; m1++) begin
      for (int m2 = 1; m2 < 16; m2++) begin
        commit(1'b1, 8'h10, 4'(m1), 1, 1'b0, 8'h0, 4'h0, 0);
        commit(1'b1, 8'h10, 4'(m2), 2, 1'b0, 8'h0, 4'h0, 0);
        if ((m1 & m2) == 0) begin
          pop_expect(8'h10, 4'(m1 | m2), mk_tid(4'(m1), 1) | mk_tid(4'(m2), 2), "R3 merge");
        end else begin
          pop_expect(8'h10, 4'(m1), mk_tid(4'(m1), 1), "R4 clash first");
          pop_expect(8'h10, 4'(m2), mk_tid(4'(m2), 2), "R4 clash second");
        end
        expect_empty("R6 drained");
      end
    end

    // R4 repoint: third group goes to the newer warp although the older has room
    commit(1'b1, 8'h20, 4'b0011, 1, 1'b0, 8'h0, 4'h0, 0);
    commit(1'b1, 8'h20, 4'b0001, 2, 1'b0, 8'h0, 4'h0, 0);
    commit(1'b1, 8'h20, 4'b0100, 3, 1'b0, 8'h0, 4'h0, 0);
    pop_expect(8'h20, 4'b0011, mk_tid(4'b0011, 1), "R4 old warp untouched");
    pop_expect(8'h20, 4'b0101, mk_tid(4'b0001, 2) | mk_tid(4'b0100, 3), "R4 repointed");
    expect_empty("R4 drained");

    // R5 same-cycle groups
    commit(1'b1, 8'h30, 4'b0011, 1, 1'b1, 8'h30, 4'b1100, 1);
    pop_expect(8'h30, 4'b1111, mk_tid(4'b1111, 1), "R5 complementary same PC");
    commit(1'b1, 8'h31, 4'b0101, 2, 1'b1, 8'h32, 4'b1010, 2);
    pop_expect(8'h31, 4'b0101, mk_tid(4'b0101, 2), "R5 taken older");
    pop_expect(8'h32, 4'b1010, mk_tid(4'b1010, 2), "R5 not-taken younger");
    commit(1'b1, 8'h33, 4'b0001, 1, 1'b1, 8'h33, 4'b0001, 2);
    pop_expect(8'h33, 4'b0001, mk_tid(4'b0001, 1), "R5 clash taken first");
    pop_expect(8'h33, 4'b0001, mk_tid(4'b0001, 2), "R5 clash not-taken second");
    expect_empty("R5 drained");

    // R7 issued forming warp takes no more threads
    commit(1'b1, 8'h50, 4'b0001, 1, 1'b0, 8'h0, 4'h0, 0);
    pop_expect(8'h50, 4'b0001, mk_tid(4'b0001, 1), "R7 first");
    commit(1'b1, 8'h50, 4'b0010, 2, 1'b0, 8'h0, 4'h0, 0);
    pop_expect(8'h50, 4'b0010, mk_tid(4'b0010, 2), "R7 reopened");
    expect_empty("R7 drained");
    // R7 issue and commit in the same cycle
    commit(1'b1, 8'h60, 4'b0001, 1, 1'b0, 8'h0, 4'h0, 0);
    #1;
    check({iss_valid, iss_pc, iss_mask} == {1'b1, 8'h60, 4'b0001}, "R7 same-cycle head",
          {19'b0, iss_valid, iss_pc, iss_mask}, {19'b0, 1'b1, 8'h60, 4'b0001});
    iss_ready = 1'b1;
    tk_req = 1'b1; tk_pc = 8'h60; tk_mask = 4'b0010; tk_tid = mk_tid(4'b0010, 2);
    @(negedge clk);
    iss_ready = 1'b0; tk_req = 1'b0; tk_mask = '0;
    pop_expect(8'h60, 4'b0010, mk_tid(4'b0010, 2), "R7 same-cycle reopened");
    expect_empty("R7 same-cycle drained");

    // R8 stall when room for two new warps is missing
    commit(1'b1, 8'h71, 4'b0001, 1, 1'b1, 8'h72, 4'b0010, 1);
    #1;
    check(cm_ready == 1'b1, "R8 ready at two held", {31'b0, cm_ready}, 32'd1);
    commit(1'b1, 8'h73, 4'b0100, 1, 1'b0, 8'h0, 4'h0, 0);
    #1;
    check(cm_ready == 1'b0, "R8 stalled at three held", {31'b0, cm_ready}, 32'd0);
    commit(1'b1, 8'h74, 4'b1000, 1, 1'b1, 8'h75, 4'b0001, 3);
    pop_expect(8'h71, 4'b0001, mk_tid(4'b0001, 1), "R8 first kept");
    #1;
    check(cm_ready == 1'b1, "R8 ready again", {31'b0, cm_ready}, 32'd1);
    pop_expect(8'h72, 4'b0010, mk_tid(4'b0010, 1), "R8 second kept");
    pop_expect(8'h73, 4'b0100, mk_tid(4'b0100, 1), "R8 third kept");
    expect_empty("R8 stalled group ignored");

    // R9 inert groups
    commit(1'b0, 8'h80, 4'b1111, 1, 1'b1, 8'h81, 4'b0000, 1);
    expect_empty("R9 no warp from inert groups");
    commit(1'b1, 8'h80, 4'b0001, 1, 1'b0, 8'h0, 4'h0, 0);
    pop_expect(8'h80, 4'b0001, mk_tid(4'b0001, 1), "R9 no stale entry");
    expect_empty("R9 drained");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule